// File: doc/BRIEF.md
# Banked Instruction Decoder for a Character Display Controller

This block sits between a host bus and the memories and analog settings of a dot-matrix character display controller. The host writes command bytes and data bytes and reads status or memory data. Command bytes are decoded against one of four banks. The bank is chosen by a sticky two-bit field in the bus-width command, so the same byte value can carry a different meaning in each bank.

The block holds one address counter. Its target is the text memory, the glyph memory or the icon memory, whichever the last address command chose. Every data access steps the counter by one in the direction set by the entry-mode flag, and the step wraps within the width of the selected memory. A busy flag blocks new writes for a set number of cycles after each accepted access. The clear command holds the flag longer.

In narrow bus mode every byte, commands and data alike, arrives as two nibble writes on the upper four bus lines, high nibble first. The memories are outside the block. It drives their strobe, address, select and write data, and it returns their read data on data reads. The remaining outputs are the display, bias, contrast, power and line-mode register values.

Top module: `chr_instr_decoder`

## Requirements
- R1: After reset the bus is 8 bits wide, the bank is 0, the counter is 0 and targets text memory, the increment flag is 1, busy is low, and every other register output is 0.
- R2: Command `001w xxbb` sets the bus width (bit 4: 1 = 8-bit, 0 = 4-bit) and the bank (bits 1:0). It is decoded in every bank, and the bank holds until the next such command.
- R3: In 4-bit mode a byte is complete only on the second accepted write: the first write supplies the high nibble and the second supplies the low nibble, both on busIn[7:4]. The register-select input of the second write decides whether the byte is a command or data.
- R4: `1aaaaaaa` (any bank) loads the 7-bit counter and selects text memory (ramSel 0). `01aaaaaa` in bank 0 loads 6 bits and selects glyph memory (ramSel 1). `0100aaaa` in bank 1 loads 4 bits and selects icon memory (ramSel 2).
- R5: A read with isData low returns {busy, counter} on busOut. A read with isData high returns ramRdata.
- R6: An accepted data write pulses ramWe, and an accepted data read pulses ramRe. The pulse comes in the same cycle, with ramAddr equal to the counter. The counter then steps +1 when the increment flag is 1 and -1 when it is 0, wrapping modulo 128, 64 or 16 for the text, glyph or icon target.
- R7: `000001is` (any bank) sets the increment flag (bit 1) and the shift-on-write flag (bit 0). `00001dcb` (any bank) sets display on (bit 2), cursor on (bit 1) and blink on (bit 0).
- R8: Command 01h zeroes the counter, selects text memory, sets the increment flag, pulses clearPulse in the accepting cycle and holds busy for CLEAR_CYC cycles. Commands 02h and 03h zero the counter and select text memory.
- R9: In bank 0, `0001 s r xx` with s=1 pulses shiftPulse, with shiftRight equal to bit 2, and leaves the counter unchanged. With s=0 it steps the counter +1 when bit 2 is 1 and -1 when bit 2 is 0.
- R10: In bank 1, `0001bbff` sets biasSel from bits 3:2 and followOpt from bits 1:0. `0110ibrf` sets icon, booster, regulator and follower enables from bits 3 to 0. `0111cccc` sets contrastLow.
- R11: In bank 2, `0001udnn` sets dblPos from bit 3, dblOn from bit 2 and lineCnt from bits 1:0.
- R12: Every accepted command and every accepted data access raise busy for BUSY_CYC cycles (CLEAR_CYC for a clear). While busy is high, writes and data reads are ignored, and that includes the nibble phase.
- R13: A byte that is not recognised in the current bank (00h in any bank; 01xxxxxx in bank 2 or 3; 0101xxxx in bank 1; 0001xxxx in bank 3) changes no state and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe, one cycle per transfer |
| rdEn | input | 1 | Host read strobe |
| isData | input | 1 | 1 = data access, 0 = command or status |
| busIn | input | 8 | Host write bus (upper nibble only in 4-bit mode) |
| busOut | output | 8 | Status or memory read data |
| busy | output | 1 | Busy flag |
| ramWe | output | 1 | Memory write strobe |
| ramRe | output | 1 | Memory read strobe |
| ramSel | output | 2 | Memory target: 0 text, 1 glyph, 2 icon |
| ramAddr | output | 7 | Address counter |
| ramWdata | output | 8 | Memory write data |
| ramRdata | input | 8 | Memory read data |
| clearPulse | output | 1 | Clear-display request |
| shiftPulse | output | 1 | Screen-shift request |
| shiftRight | output | 1 | Screen-shift direction |
| busWide | output | 1 | 1 = 8-bit bus |
| tableSel | output | 2 | Current command bank |
| incMode | output | 1 | Counter increments on access |
| entryShift | output | 1 | Shift-on-write flag |
| dispOn | output | 1 | Display enable |
| cursorOn | output | 1 | Cursor enable |
| blinkOn | output | 1 | Blink enable |
| biasSel | output | 2 | Bias selection |
| followOpt | output | 2 | Follower options |
| iconOn | output | 1 | Icon enable |
| boostOn | output | 1 | Booster enable |
| regOn | output | 1 | Regulator enable |
| followOn | output | 1 | Follower enable |
| contrastLow | output | 4 | Contrast low nibble |
| dblPos | output | 1 | Double-height position |
| dblOn | output | 1 | Double-height enable |
| lineCnt | output | 2 | Line-count code |

## Verification
The memory strobes, write data, clear and shift pulses and status read data are combinational. They are due in the same cycle as the write or read that completes a byte. Register outputs and the counter take their new values at the next rising edge, and busy stays high for exactly BUSY_CYC or CLEAR_CYC cycles after that edge. The bench drives inputs on the falling edge and checks the same-cycle results 1 ns later. It checks register outputs and busy at the following falling edge against a bench model that is advanced once per rising edge.

// File: rtl/chr_dec_pkg.sv
package chr_dec_pkg;
  localparam int AC_W   = 7;
  localparam int CG_W   = 6;
  localparam int ICON_W = 4;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;

  typedef enum logic [1:0] {
    TGT_TEXT  = 2'd0,
    TGT_GLYPH = 2'd1,
    TGT_ICON  = 2'd2
  } ramTgt_e;

  typedef struct packed {
    logic              ldFunc;
    logic              ldEntry;
    logic              ldDisp;
    logic              ldBias;
    logic              ldPower;
    logic              ldContrast;
    logic              ldMode;
    logic              ldAddr;
    ramTgt_e           addrTgt;
    logic              home;
    logic              clear;
    logic              step;
    logic              stepUseEntry;
    logic              stepUp;
    logic [BYTE_W-1:0] arg;
  } ctrlStrobe_t;

  function automatic logic [AC_W-1:0] tgtMask(input ramTgt_e t);
    case (t)
      TGT_GLYPH: tgtMask = AC_W'((1 << CG_W) - 1);
      TGT_ICON:  tgtMask = AC_W'((1 << ICON_W) - 1);
      default:   tgtMask = '1;
    endcase
  endfunction
endpackage

// File: rtl/chr_dec_ctrl.sv
module chr_dec_ctrl
  import chr_dec_pkg::*;
#(
  parameter int BUSY_CYC  = 3,
  parameter int CLEAR_CYC = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              isData,
  input  logic [BYTE_W-1:0] busIn,
  input  logic              busWide,
  input  logic [1:0]        tableSel,
  output ctrlStrobe_t       sb,
  output logic              busy,
  output logic              ramWe,
  output logic              ramRe,
  output logic [BYTE_W-1:0] ramWdata,
  output logic              clearPulse,
  output logic              shiftPulse,
  output logic              shiftRight
);
  localparam int CNT_W = $clog2(CLEAR_CYC + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             nibPending;
  logic [NIB_W-1:0] nibHi;
  logic             wrOk, byteDone, instrGo, dataWr, dataRd, recog;
  logic [BYTE_W-1:0] fullByte;

  assign busy     = (busyCnt != '0);
  assign wrOk     = wrEn && !busy;
  assign byteDone = wrOk && (busWide || nibPending);
  assign fullByte = busWide ? busIn : {nibHi, busIn[BYTE_W-1:NIB_W]};
  assign instrGo  = byteDone && !isData;
  assign dataWr   = byteDone && isData;
  assign dataRd   = rdEn && isData && !busy && !wrEn;

  // nibble pairing for the narrow bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nibPending <= 1'b0;
      nibHi      <= '0;
    end else if (busWide) begin
      nibPending <= 1'b0;
    end else if (wrOk) begin
      if (!nibPending) nibHi <= busIn[BYTE_W-1:NIB_W];
      nibPending <= !nibPending;
    end
  end

  // banked decode
  always_comb begin
    sb         = '0;
    sb.arg     = fullByte;
    sb.addrTgt = TGT_TEXT;
    recog      = 1'b0;
    shiftPulse = 1'b0;
    if (instrGo) begin
      casez (fullByte)
        8'b1???????: begin sb.ldAddr = 1'b1; recog = 1'b1; end
        8'b00000001: begin sb.clear = 1'b1; recog = 1'b1; end
        8'b0000001?: begin sb.home = 1'b1; recog = 1'b1; end
        8'b000001??: begin sb.ldEntry = 1'b1; recog = 1'b1; end
        8'b00001???: begin sb.ldDisp = 1'b1; recog = 1'b1; end
        8'b001?????: begin sb.ldFunc = 1'b1; recog = 1'b1; end
        8'b0001????: begin
          case (tableSel)
            2'd0: begin
              recog = 1'b1;
              if (fullByte[3]) shiftPulse = 1'b1;
              else begin
                sb.step   = 1'b1;
                sb.stepUp = fullByte[2];
              end
            end
            2'd1: begin sb.ldBias = 1'b1; recog = 1'b1; end
            2'd2: begin sb.ldMode = 1'b1; recog = 1'b1; end
            default: recog = 1'b0;
          endcase
        end
        8'b01??????: begin
          if (tableSel == 2'd0) begin
            sb.ldAddr  = 1'b1;
            sb.addrTgt = TGT_GLYPH;
            recog      = 1'b1;
          end else if (tableSel == 2'd1) begin
            case (fullByte[5:4])
              2'b00: begin sb.ldAddr = 1'b1; sb.addrTgt = TGT_ICON; recog = 1'b1; end
              2'b10: begin sb.ldPower = 1'b1; recog = 1'b1; end
              2'b11: begin sb.ldContrast = 1'b1; recog = 1'b1; end
              default: recog = 1'b0;
            endcase
          end
        end
        default: recog = 1'b0;
      endcase
    end else if (dataWr || dataRd) begin
      sb.step         = 1'b1;
      sb.stepUseEntry = 1'b1;
    end
  end

  assign ramWe      = dataWr;
  assign ramRe      = dataRd;
  assign ramWdata   = fullByte;
  assign clearPulse = sb.clear;
  assign shiftRight = shiftPulse && fullByte[2];

  // busy countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyCnt <= '0;
    else if (sb.clear) busyCnt <= CNT_W'(CLEAR_CYC);
    else if (recog || dataWr || dataRd) busyCnt <= CNT_W'(BUSY_CYC);
    else if (busy) busyCnt <= busyCnt - 1'b1;
  end
endmodule

// File: rtl/chr_dec_dp.sv
module chr_dec_dp
  import chr_dec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     sb,
  output logic [AC_W-1:0] ac,
  output ramTgt_e         tgt,
  output logic            busWide,
  output logic [1:0]      tableSel,
  output logic            incMode,
  output logic            entryShift,
  output logic            dispOn,
  output logic            cursorOn,
  output logic            blinkOn,
  output logic [1:0]      biasSel,
  output logic [1:0]      followOpt,
  output logic            iconOn,
  output logic            boostOn,
  output logic            regOn,
  output logic            followOn,
  output logic [3:0]      contrastLow,
  output logic            dblPos,
  output logic            dblOn,
  output logic [1:0]      lineCnt
);
  logic            stepDirUp;
  logic [AC_W-1:0] stepVal, loadVal;

  assign stepDirUp = sb.stepUseEntry ? incMode : sb.stepUp;
  assign stepVal   = (stepDirUp ? ac + 1'b1 : ac - 1'b1) & tgtMask(tgt);
  assign loadVal   = sb.arg[AC_W-1:0] & tgtMask(sb.addrTgt);

  // address counter and target
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac  <= '0;
      tgt <= TGT_TEXT;
    end else if (sb.clear || sb.home) begin
      ac  <= '0;
      tgt <= TGT_TEXT;
    end else if (sb.ldAddr) begin
      ac  <= loadVal;
      tgt <= sb.addrTgt;
    end else if (sb.step) begin
      ac  <= stepVal;
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWide     <= 1'b1;
      tableSel    <= 2'd0;
      incMode     <= 1'b1;
      entryShift  <= 1'b0;
      dispOn      <= 1'b0;
      cursorOn    <= 1'b0;
      blinkOn     <= 1'b0;
      biasSel     <= '0;
      followOpt   <= '0;
      iconOn      <= 1'b0;
      boostOn     <= 1'b0;
      regOn       <= 1'b0;
      followOn    <= 1'b0;
      contrastLow <= '0;
      dblPos      <= 1'b0;
      dblOn       <= 1'b0;
      lineCnt     <= '0;
    end else begin
      if (sb.ldFunc) begin
        busWide  <= sb.arg[4];
        tableSel <= sb.arg[1:0];
      end
      if (sb.ldEntry) begin
        incMode    <= sb.arg[1];
        entryShift <= sb.arg[0];
      end
      if (sb.clear) incMode <= 1'b1;
      if (sb.ldDisp) begin
        dispOn   <= sb.arg[2];
        cursorOn <= sb.arg[1];
        blinkOn  <= sb.arg[0];
      end
      if (sb.ldBias) begin
        biasSel   <= sb.arg[3:2];
        followOpt <= sb.arg[1:0];
      end
      if (sb.ldPower) begin
        iconOn   <= sb.arg[3];
        boostOn  <= sb.arg[2];
        regOn    <= sb.arg[1];
        followOn <= sb.arg[0];
      end
      if (sb.ldContrast) contrastLow <= sb.arg[3:0];
      if (sb.ldMode) begin
        dblPos  <= sb.arg[3];
        dblOn   <= sb.arg[2];
        lineCnt <= sb.arg[1:0];
      end
    end
  end
endmodule

// File: rtl/chr_instr_decoder.sv
module chr_instr_decoder
  import chr_dec_pkg::*;
#(
  parameter int BUSY_CYC  = 3,
  parameter int CLEAR_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic       isData,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busy,
  output logic       ramWe,
  output logic       ramRe,
  output logic [1:0] ramSel,
  output logic [6:0] ramAddr,
  output logic [7:0] ramWdata,
  input  logic [7:0] ramRdata,
  output logic       clearPulse,
  output logic       shiftPulse,
  output logic       shiftRight,
  output logic       busWide,
  output logic [1:0] tableSel,
  output logic       incMode,
  output logic       entryShift,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic [1:0] biasSel,
  output logic [1:0] followOpt,
  output logic       iconOn,
  output logic       boostOn,
  output logic       regOn,
  output logic       followOn,
  output logic [3:0] contrastLow,
  output logic       dblPos,
  output logic       dblOn,
  output logic [1:0] lineCnt
);
  ctrlStrobe_t sb;
  ramTgt_e     tgt;

  chr_dec_ctrl #(.BUSY_CYC(BUSY_CYC), .CLEAR_CYC(CLEAR_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .isData(isData),
    .busIn(busIn), .busWide(busWide), .tableSel(tableSel), .sb(sb),
    .busy(busy), .ramWe(ramWe), .ramRe(ramRe), .ramWdata(ramWdata),
    .clearPulse(clearPulse), .shiftPulse(shiftPulse), .shiftRight(shiftRight)
  );

  chr_dec_dp u_dp (
    .clk(clk), .rstN(rstN), .sb(sb), .ac(ramAddr), .tgt(tgt),
    .busWide(busWide), .tableSel(tableSel), .incMode(incMode),
    .entryShift(entryShift), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .biasSel(biasSel), .followOpt(followOpt),
    .iconOn(iconOn), .boostOn(boostOn), .regOn(regOn), .followOn(followOn),
    .contrastLow(contrastLow), .dblPos(dblPos), .dblOn(dblOn), .lineCnt(lineCnt)
  );

  assign ramSel = tgt;
  assign busOut = isData ? ramRdata : {busy, ramAddr};
endmodule

// File: rtl/chr_instr_decoder_chk.sv
module chr_instr_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       busy,
  input logic       ramWe,
  input logic       ramRe,
  input logic [1:0] ramSel,
  input logic [6:0] ramAddr,
  input logic       incMode,
  input logic [1:0] tableSel,
  input logic       clearPulse,
  input logic       shiftPulse
);
  AST_NO_ACCESS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!ramWe && !ramRe)); // R12
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> ($stable(ramAddr) && $stable(tableSel) && $stable(ramSel))); // R12
  AST_TEXT_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && incMode && ramSel == 2'd0) |=> (ramAddr == $past(ramAddr) + 7'd1)); // R6
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ramWe, ramRe, clearPulse, shiftPulse})); // R6
  AST_CLEAR_HOMES: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (ramAddr == 7'd0 && ramSel == 2'd0 && incMode && busy)); // R8
  AST_SHIFT_KEEPS_AC: assert property (@(posedge clk) disable iff (!rstN)
    shiftPulse |=> $stable(ramAddr)); // R9
endmodule

bind chr_instr_decoder chr_instr_decoder_chk u_chk (.*);

// File: tb/chr_instr_decoder_tb.sv
`timescale 1ns/1ps
module chr_instr_decoder_tb;
  localparam int BUSY_N  = 3;
  localparam int CLEAR_N = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, isData = 1'b0;
  logic [7:0] busIn = '0, ramRdata = '0;
  logic [7:0] busOut, ramWdata;
  logic busy, ramWe, ramRe, clearPulse, shiftPulse, shiftRight;
  logic [1:0] ramSel, tableSel, biasSel, followOpt, lineCnt;
  logic [6:0] ramAddr;
  logic busWide, incMode, entryShift, dispOn, cursorOn, blinkOn;
  logic iconOn, boostOn, regOn, followOn, dblPos, dblOn;
  logic [3:0] contrastLow;

  always #2 clk = ~clk;

  chr_instr_decoder #(.BUSY_CYC(BUSY_N), .CLEAR_CYC(CLEAR_N)) u_dut (.*);

  int nVec = 0, nFail = 0;
  bit done = 0;

  // bench model
  logic eWide, eInc, eS, eD, eC, eB, eIon, eBon, eRon, eFon, eUd, eDh, eNibP;
  logic [1:0] eTbl, eBias, eOpf, eLines, eTgt;
  logic [3:0] eCon, eNibHi;
  logic [6:0] eAc;
  int eBusy;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic modelReset();
    eWide = 1; eTbl = 0; eInc = 1; eS = 0; eD = 0; eC = 0; eB = 0;
    eBias = 0; eOpf = 0; eIon = 0; eBon = 0; eRon = 0; eFon = 0; eCon = 0;
    eUd = 0; eDh = 0; eLines = 0; eAc = 0; eTgt = 0; eBusy = 0;
    eNibP = 0; eNibHi = 0;
  endtask

  task automatic stepAc(input logic up);
    int m;
    m = (eTgt == 1) ? 63 : (eTgt == 2) ? 15 : 127;
    eAc = 7'((up ? int'(eAc) + 1 : int'(eAc) - 1) & m);
  endtask

  task automatic decode(input logic [7:0] f, output bit rec);
    rec = 1;
    casez (f)
      8'b1???????: begin eTgt = 0; eAc = f[6:0]; end
      8'b00000001: begin eAc = 0; eTgt = 0; eInc = 1; end
      8'b0000001?: begin eAc = 0; eTgt = 0; end
      8'b000001??: begin eInc = f[1]; eS = f[0]; end
      8'b00001???: begin eD = f[2]; eC = f[1]; eB = f[0]; end
      8'b001?????: begin eWide = f[4]; eTbl = f[1:0]; end
      8'b0001????: begin
        if (eTbl == 0) begin if (!f[3]) stepAc(f[2]); end
        else if (eTbl == 1) begin eBias = f[3:2]; eOpf = f[1:0]; end
        else if (eTbl == 2) begin eUd = f[3]; eDh = f[2]; eLines = f[1:0]; end
        else rec = 0;
      end
      8'b01??????: begin
        if (eTbl == 0) begin eTgt = 1; eAc = {1'b0, f[5:0]}; end
        else if (eTbl == 1) begin
          case (f[5:4])
            2'b00: begin eTgt = 2; eAc = {3'b0, f[3:0]}; end
            2'b10: begin eIon = f[3]; eBon = f[2]; eRon = f[1]; eFon = f[0]; end
            2'b11: eCon = f[3:0];
            default: rec = 0;
          endcase
        end else rec = 0;
      end
      default: rec = 0;
    endcase
  endtask

  task automatic checkRegs();
    chk(busy, eBusy != 0, "R12 busy");
    chk(ramAddr, eAc, "R6 counter");
    chk(ramSel, eTgt, "R4 target");
    chk(busWide, eWide, "R2 width");
    chk(tableSel, eTbl, "R2 bank");
    chk({incMode, entryShift, dispOn, cursorOn, blinkOn}, {eInc, eS, eD, eC, eB}, "R7 entry/display");
    chk({biasSel, followOpt, iconOn, boostOn, regOn, followOn, contrastLow},
        {eBias, eOpf, eIon, eBon, eRon, eFon, eCon}, "R10 analog regs");
    chk({dblPos, dblOn, lineCnt}, {eUd, eDh, eLines}, "R11 line mode");
  endtask

  // one clock: drive at falling edge, check strobes, advance model, check registers
  task automatic cyc(input logic wr, input logic rd, input logic dat, input logic [7:0] bus);
    logic ok, fin, dWr, dRd; logic [7:0] f; bit rec; int ld;
    wrEn = wr; rdEn = rd; isData = dat; busIn = bus; ramRdata = 8'($urandom);
    #1;
    ok  = wr && (eBusy == 0);
    fin = ok && (eWide || eNibP);
    f   = eWide ? bus : {eNibHi, bus[7:4]};
    dWr = fin && dat;
    dRd = rd && dat && (eBusy == 0) && !wr;
    chk(ramWe, dWr, "R6 ramWe");
    chk(ramRe, dRd, "R6 ramRe");
    if (dWr) chk(ramWdata, f, "R3 write data");
    if (dWr || dRd) chk(ramAddr, eAc, "R6 access address");
    if (rd) chk(busOut, dat ? ramRdata : {eBusy != 0, eAc}, "R5 read data");
    chk(clearPulse, fin && !dat && f == 8'h01, "R8 clearPulse");
    chk(shiftPulse, fin && !dat && eTbl == 0 && f[7:4] == 4'h1 && f[3], "R9 shiftPulse");
    if (fin && !dat && eTbl == 0 && f[7:4] == 4'h1 && f[3]) chk(shiftRight, f[2], "R9 shiftRight");
    @(posedge clk);
    ld = 0;
    if (eWide) eNibP = 0;
    else if (ok) begin if (!eNibP) eNibHi = bus[7:4]; eNibP = !eNibP; end
    if (dWr || dRd) begin stepAc(eInc); ld = BUSY_N; end
    else if (fin) begin decode(f, rec); if (rec) ld = (f == 8'h01) ? CLEAR_N : BUSY_N; end
    if (ld != 0) eBusy = ld; else if (eBusy > 0) eBusy--;
    @(negedge clk);
    checkRegs();
  endtask

  task automatic idle();
    while (eBusy != 0) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic cmd(input logic [7:0] b);
    cyc(1, 0, 0, b); idle();
  endtask

  task automatic dat(input logic [7:0] b);
    cyc(1, 0, 1, b); idle();
  endtask

  initial begin
    void'($urandom(32'h1d5e_ed07));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: state after reset
    checkRegs();
    chk(busy, 0, "R1 busy after reset");
    chk({busWide, incMode, ramAddr}, {1'b1, 1'b1, 7'd0}, "R1 reset width/inc/counter");

    // R4 R6: text wrap upward, then downward
    cmd(8'hFE); dat(8'hA1); dat(8'hA2);
    chk(ramAddr, 7'd0, "R6 text wrap to 0");
    cmd(8'h04); dat(8'h33);
    chk(ramAddr, 7'h7F, "R6 decrement wrap");
    cmd(8'h06);
    // glyph target wraps in 6 bits
    cmd(8'h7F); dat(8'h11);
    chk({ramSel, ramAddr}, {2'd1, 7'd0}, "R4 glyph wrap");
    // R7 display control
    cmd(8'h0D);
    // bank 1
    cmd(8'h31); cmd(8'h4F); dat(8'h55);
    chk({ramSel, ramAddr}, {2'd2, 7'd0}, "R4 icon wrap");
    cyc(1, 0, 0, 8'h50); // R13 unrecognised in bank 1
    chk(busy, 0, "R13 no busy on unknown");
    cmd(8'h6B); cmd(8'h75); cmd(8'h1E); // R10
    // bank 2
    cmd(8'h32); cmd(8'h1D); cyc(1, 0, 0, 8'h45); // R11, R13
    // bank 3
    cmd(8'h33); cyc(1, 0, 0, 8'h1F); cyc(1, 0, 0, 8'h00); // R13
    chk(busy, 0, "R13 bank 3 unknown");
    // bank 0 shifts (R9)
    cmd(8'h30); cmd(8'h90); cmd(8'h1C); cmd(8'h18); cmd(8'h14); cmd(8'h10);
    chk(ramAddr, 7'h10, "R9 cursor right then left");
    // R12 busy drops a write
    cyc(1, 0, 0, 8'h90); cyc(1, 0, 0, 8'h85); idle();
    chk(ramAddr, 7'h10, "R12 busy write dropped");
    // R5 status and data read
    cyc(0, 1, 0, 8'h00); cyc(0, 1, 1, 8'h00); idle();
    // R3 4-bit mode
    cmd(8'h20);
    cyc(1, 0, 0, 8'h80); chk(busy, 0, "R3 first nibble no busy");
    cmd(8'h30);
    chk(ramAddr, 7'h03, "R3 paired address");
    cyc(1, 0, 1, 8'h40); dat(8'h10);
    cyc(1, 0, 0, 8'h00); cyc(1, 0, 0, 8'h10);
    chk(busy, 1, "R8 clear busy");
    idle();
    cyc(1, 0, 0, 8'h30); cmd(8'h00); // back to 8-bit, bank 0
    chk(busWide, 1, "R2 width restored");

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1:    cyc(0, 0, 0, 8'h00);
        2, 3, 4: cyc(1, 0, 0, 8'($urandom));
        5:       cyc(1, 0, 1, 8'($urandom));
        default: cyc(0, 1, 1'($urandom), 8'h00);
      endcase
    end
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end
endmodule